// File: doc/BRIEF.md
# Watchdog and Reset Status Controller

This block gathers every reason for restarting a small processor core into one stretched system reset. It also runs the watchdog that guards the core's software and keeps two status bits that let firmware tell which restart or wake path last occurred. The reset sources are power-on, low-voltage detect, an optional active-low external reset pin and watchdog overflow. Detection of power and voltage events happens elsewhere and arrives here as digital levels.

The watchdog counts pulses of a separate slow tick. It can route them through a 3-bit-selected power-of-two prescaler first. The core sends two strobes: one clears the watchdog and one enters sleep. While the core sleeps, a watchdog overflow either resets it or, when internal watchdog wake is enabled, produces a wake pulse instead. Enabled pin-change inputs can also wake a sleeping core. Once the last active reset source goes away, the reset output is held for a further number of reference ticks, and one configuration input chooses between a short and a long hold.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst`, `to_flag` and `pd_flag` are all 1. After `por_n` rises, `sys_rst` stays high for one cycle plus the selected hold.
- R2: A cycle with `lvd_req` high sets `sys_rst` in the next cycle and sets `to_flag`=1 and `pd_flag`=1.
- R3: With `ext_rst_en`=1, a low `ext_rst_n` asserts `sys_rst` in the next cycle. If the core is asleep, this sets `to_flag`=1, `pd_flag`=0 and clears `asleep`. If the core is running, both flags keep their values. With `ext_rst_en`=0 the pin has no effect on `sys_rst` or on the flags.
- R4: With `wdt_en`=1, overflow occurs on the 2^WDT_W-th counted step after a clear. Each step is one `wdt_tick` when `psa`=0, and 2^`ps` ticks when `psa`=1 (ps = 0 to 7 gives 1:1 to 1:128). With `wdt_en`=0 the watchdog never overflows.
- R5: A watchdog overflow while running asserts `sys_rst` and sets `to_flag`=0, `pd_flag`=1.
- R6: A watchdog overflow while asleep, with internal watchdog wake off, asserts `sys_rst` and sets `to_flag`=0, `pd_flag`=0.
- R7: A watchdog overflow while asleep, with `iwake_en`=1 and `wdt_en`=1, gives a one-cycle `wake` pulse instead of a reset. It sets `to_flag`=0, `pd_flag`=0 and clears `asleep`.
- R8: `clr_wdt` zeroes the watchdog counter and prescaler and sets `to_flag`=1, `pd_flag`=1. A clear that arrives in the same cycle as the final tick suppresses that overflow.
- R9: `sleep_cmd` sets `asleep`=1, `to_flag`=1, `pd_flag`=0.
- R10: While asleep, a pulse on `pin_chg[i]` with `wake_src_en[i]`=1 gives a `wake` pulse, sets `to_flag`=1, `pd_flag`=0 and clears `asleep`. Bit 7 of the enable is forced off while `iwake_en` and `wdt_en` are both 1. Pin changes while awake are ignored.
- R11: Every reset is held for LONG_DLY reference ticks after its last source goes inactive when `long_por`=1, and for SHORT_DLY ticks when `long_por`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| lvd_req | input | 1 | Low-voltage detect request, level |
| ext_rst_n | input | 1 | External reset pin, active low |
| ext_rst_en | input | 1 | Makes the external pin act as a reset |
| long_por | input | 1 | Selects the long reset hold |
| ref_tick | input | 1 | Reference tick that times the reset hold |
| wdt_tick | input | 1 | Slow watchdog tick, one-cycle pulse |
| wdt_en | input | 1 | Watchdog enable |
| psa | input | 1 | Routes the prescaler to the watchdog |
| ps | input | PS_W | Prescaler ratio select |
| iwake_en | input | 1 | Watchdog overflow in sleep wakes instead of resets |
| clr_wdt | input | 1 | Clear-watchdog strobe from the core |
| sleep_cmd | input | 1 | Sleep strobe from the core |
| wake_src_en | input | PINS | Per-pin wake enables |
| pin_chg | input | PINS | Per-pin change pulses |
| sys_rst | output | 1 | Stretched system reset |
| wake | output | 1 | One-cycle wake pulse |
| to_flag | output | 1 | Timeout status bit |
| pd_flag | output | 1 | Power-down status bit |
| asleep | output | 1 | Core is in sleep |
| wdt_ovf | output | 1 | Watchdog overflow pulse |

## Verification
The clear-watchdog strobe and the tick that completes the timeout can land in the same cycle, and the clear must win. The bench arranges this by counting ticks up to one short of the period and then raising the tick together with `clr_wdt`. It passes only if no reset appears, the status reads 1/1, and a full fresh period is then needed before the next overflow. A watchdog overflow that arrives while asleep is also checked with wake enabled and with wake disabled, and the bench compares reset versus wake and the resulting flag pair.

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl #(
  parameter int WDT_W     = 8,
  parameter int PRE_W     = 7,
  parameter int PS_W      = $clog2(PRE_W + 1),
  parameter int SHORT_DLY = 3,
  parameter int LONG_DLY  = 100,
  parameter int PINS      = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            lvd_req,
  input  logic            ext_rst_n,
  input  logic            ext_rst_en,
  input  logic            long_por,
  input  logic            ref_tick,
  input  logic            wdt_tick,
  input  logic            wdt_en,
  input  logic            psa,
  input  logic [PS_W-1:0] ps,
  input  logic            iwake_en,
  input  logic            clr_wdt,
  input  logic            sleep_cmd,
  input  logic [PINS-1:0] wake_src_en,
  input  logic [PINS-1:0] pin_chg,
  output logic            sys_rst,
  output logic            wake,
  output logic            to_flag,
  output logic            pd_flag,
  output logic            asleep,
  output logic            wdt_ovf
);

  localparam int HOLD_W = $clog2(LONG_DLY + 1);

  logic [WDT_W-1:0]  wcnt;
  logic [PRE_W-1:0]  pre;
  logic [HOLD_W-1:0] hold;
  logic por_pend, ext_q, ovf_q, wake_q, to_q, pd_q, sleep_q;

  logic              iwk, ext_act, ext_edge, pre_hit, adv, ovf_now;
  logic              ovf_wake, ovf_rst, src_any, pin_hit;
  logic [PRE_W:0]    one_sh;
  logic [PRE_W-1:0]  pre_mask;
  logic [PINS-1:0]   pin_mask;
  logic [HOLD_W-1:0] dly;

  assign iwk      = iwake_en & wdt_en;
  assign ext_act  = ext_rst_en & ~ext_rst_n;
  assign ext_edge = ext_act & ~ext_q;
  assign one_sh   = (PRE_W + 1)'(1) << ps;
  assign pre_mask = one_sh[PRE_W-1:0] - PRE_W'(1);
  assign pre_hit  = (pre & pre_mask) == pre_mask;
  assign adv      = wdt_en & wdt_tick & (~psa | pre_hit);
  assign ovf_now  = adv & (&wcnt) & ~clr_wdt & ~sys_rst;
  assign ovf_wake = ovf_q & sleep_q & iwk;
  assign ovf_rst  = ovf_q & ~ovf_wake;
  assign src_any  = por_pend | lvd_req | ext_act | ovf_rst;
  assign pin_hit  = sleep_q & (|(pin_chg & pin_mask)) & ~sys_rst;
  assign dly      = long_por ? HOLD_W'(LONG_DLY) : HOLD_W'(SHORT_DLY);

  always_comb begin
    pin_mask = wake_src_en;
    if (iwk) pin_mask[PINS-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wcnt  <= '0;
      pre   <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_now;
      if (sys_rst | src_any | clr_wdt | ~wdt_en) begin
        wcnt <= '0;
        pre  <= '0;
      end else if (wdt_tick) begin
        pre <= pre + PRE_W'(1);
        if (adv) wcnt <= wcnt + WDT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_pend <= 1'b1;
      hold     <= '0;
      ext_q    <= 1'b0;
      wake_q   <= 1'b0;
      to_q     <= 1'b1;
      pd_q     <= 1'b1;
      sleep_q  <= 1'b0;
    end else begin
      por_pend <= 1'b0;
      ext_q    <= ext_act;
      wake_q   <= 1'b0;
      if (src_any) hold <= dly;
      else if (ref_tick && hold != '0) hold <= hold - HOLD_W'(1);

      if (por_pend | lvd_req) begin
        to_q    <= 1'b1;
        pd_q    <= 1'b1;
        sleep_q <= 1'b0;
      end else if (ovf_q) begin
        to_q    <= 1'b0;
        pd_q    <= ~sleep_q;
        sleep_q <= 1'b0;
        wake_q  <= ovf_wake & ~src_any;
      end else if (ext_act) begin
        if (ext_edge && sleep_q) begin
          to_q <= 1'b1;
          pd_q <= 1'b0;
        end
        sleep_q <= 1'b0;
      end else if (sys_rst) begin
        sleep_q <= 1'b0;
      end else if (pin_hit) begin
        wake_q  <= 1'b1;
        to_q    <= 1'b1;
        pd_q    <= 1'b0;
        sleep_q <= 1'b0;
      end else if (clr_wdt) begin
        to_q <= 1'b1;
        pd_q <= 1'b1;
      end else if (sleep_cmd) begin
        to_q    <= 1'b1;
        pd_q    <= 1'b0;
        sleep_q <= 1'b1;
      end
    end
  end

  assign sys_rst = por_pend | (hold != '0);
  assign wake    = wake_q;
  assign to_flag = to_q;
  assign pd_flag = pd_q;
  assign asleep  = sleep_q;
  assign wdt_ovf = ovf_q;

endmodule

// File: rtl/wdt_rst_ctrl_chk.sv
module wdt_rst_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic lvd_req,
  input logic ext_rst_n,
  input logic ext_rst_en,
  input logic wdt_en,
  input logic clr_wdt,
  input logic sleep_cmd,
  input logic sys_rst,
  input logic wake,
  input logic to_flag,
  input logic pd_flag,
  input logic asleep,
  input logic wdt_ovf
);

  a_r2_lvd_resets: assert property (@(posedge clk) disable iff (!por_n)
    lvd_req |=> (sys_rst && to_flag && pd_flag));

  a_r3_ext_resets: assert property (@(posedge clk) disable iff (!por_n)
    (ext_rst_en && !ext_rst_n) |=> sys_rst);

  a_r4_disabled_no_ovf: assert property (@(posedge clk) disable iff (!por_n)
    !wdt_en |=> !wdt_ovf);

  a_r7_wake_not_reset: assert property (@(posedge clk) disable iff (!por_n)
    wake |-> !sys_rst);

  a_r8_clr_sets_status: assert property (@(posedge clk) disable iff (!por_n)
    (clr_wdt && !sys_rst && !lvd_req && !(ext_rst_en && !ext_rst_n) && !wdt_ovf && !asleep)
    |=> (to_flag && pd_flag));

  a_r9_sleep_status: assert property (@(posedge clk) disable iff (!por_n)
    (sleep_cmd && !clr_wdt && !sys_rst && !lvd_req && !(ext_rst_en && !ext_rst_n) && !wdt_ovf && !asleep)
    |=> (asleep && to_flag && !pd_flag));

endmodule

bind wdt_rst_ctrl wdt_rst_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .lvd_req(lvd_req), .ext_rst_n(ext_rst_n),
  .ext_rst_en(ext_rst_en), .wdt_en(wdt_en), .clr_wdt(clr_wdt),
  .sleep_cmd(sleep_cmd), .sys_rst(sys_rst), .wake(wake), .to_flag(to_flag),
  .pd_flag(pd_flag), .asleep(asleep), .wdt_ovf(wdt_ovf)
);

// File: tb/wdt_rst_ctrl_test.sv
module wdt_rst_ctrl_test;
  localparam int WDT_W = 4;
  localparam int SDLY  = 2;
  localparam int LDLY  = 7;

  logic clk = 1'b0;
  logic por_n = 1'b0, lvd_req = 1'b0, ext_rst_n = 1'b1, ext_rst_en = 1'b0;
  logic long_por = 1'b1, ref_tick = 1'b1, wdt_tick = 1'b0, wdt_en = 1'b0, psa = 1'b0;
  logic [2:0] ps = '0;
  logic iwake_en = 1'b0, clr_wdt = 1'b0, sleep_cmd = 1'b0;
  logic [7:0] wake_src_en = '0, pin_chg = '0;
  logic sys_rst, wake, to_flag, pd_flag, asleep, wdt_ovf;
  int checks = 0, fails = 0, n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_rst_ctrl #(.WDT_W(WDT_W), .SHORT_DLY(SDLY), .LONG_DLY(LDLY)) uut (
    .clk(clk), .por_n(por_n), .lvd_req(lvd_req), .ext_rst_n(ext_rst_n),
    .ext_rst_en(ext_rst_en), .long_por(long_por), .ref_tick(ref_tick),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .psa(psa), .ps(ps), .iwake_en(iwake_en),
    .clr_wdt(clr_wdt), .sleep_cmd(sleep_cmd), .wake_src_en(wake_src_en),
    .pin_chg(pin_chg), .sys_rst(sys_rst), .wake(wake), .to_flag(to_flag),
    .pd_flag(pd_flag), .asleep(asleep), .wdt_ovf(wdt_ovf));

  function automatic int period(bit p, int s);
    return (1 << WDT_W) * (p ? (1 << s) : 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(int k);
    for (int i = 0; i < k; i++) begin
      wdt_tick = 1'b1; cyc(); wdt_tick = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    clr_wdt = 1'b1; cyc(); clr_wdt = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleep_cmd = 1'b1; cyc(); sleep_cmd = 1'b0;
  endtask

  task automatic meas(output int cnt);
    cnt = 0;
    while (sys_rst && cnt < 1000) begin cyc(); cnt++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7219));
    cyc(); cyc();
    chk("R1 rst during por", {sys_rst, to_flag, pd_flag}, 3'b111);
    por_n = 1'b1;
    meas(n);
    chk("R1 por hold length", n, LDLY + 1);

    wdt_en = 1'b1;
    for (int it = 0; it < 6; it++) begin
      int per;
      psa = 1'($urandom % 2);
      ps  = 3'($urandom % 8);
      per = period(psa, int'(ps));
      pulse_clr();
      chk("R8 clr status", {to_flag, pd_flag}, 2'b11);
      if ($urandom % 2 == 1) begin
        ticks(int'($urandom % per));
        pulse_clr();
      end
      ticks(per - 1); cyc();
      chk("R4 no ovf before period", sys_rst, 1'b0);
      ticks(1); cyc();
      chk("R5 running ovf reset", {sys_rst, to_flag, pd_flag}, 3'b101);
      meas(n);
      chk("R11 long hold", n, LDLY);
    end

    psa = 1'b0;
    pulse_clr();
    ticks(period(0, 0) - 1);
    wdt_tick = 1'b1; clr_wdt = 1'b1; cyc(); wdt_tick = 1'b0; clr_wdt = 1'b0;
    cyc();
    chk("R8 clr beats final tick", {sys_rst, to_flag, pd_flag}, 3'b011);
    ticks(period(0, 0) - 1); cyc();
    chk("R8 count restarted", sys_rst, 1'b0);
    ticks(1); cyc();
    chk("R8 full period then ovf", sys_rst, 1'b1);
    meas(n);

    wdt_en = 1'b0;
    ticks(3 * period(0, 0)); cyc();
    chk("R4 disabled no reset", sys_rst, 1'b0);

    long_por = 1'b0;
    lvd_req = 1'b1; cyc(); lvd_req = 1'b0;
    chk("R2 lvd reset status", {sys_rst, to_flag, pd_flag}, 3'b111);
    meas(n);
    chk("R11 short hold", n, SDLY);
    long_por = 1'b1;

    pulse_sleep();
    chk("R9 sleep status", {asleep, to_flag, pd_flag}, 3'b110);
    wake_src_en = 8'h01;
    pin_chg = 8'h02; cyc(); pin_chg = 8'h00;
    chk("R10 masked pin no wake", {wake, asleep}, 2'b01);
    pin_chg = 8'h01; cyc(); pin_chg = 8'h00;
    chk("R10 pin wake", {wake, asleep, to_flag, pd_flag}, 4'b1010);
    pin_chg = 8'h01; cyc(); pin_chg = 8'h00;
    chk("R10 awake pin ignored", {wake, asleep}, 2'b00);

    wdt_en = 1'b1; iwake_en = 1'b1; wake_src_en = 8'h80;
    pulse_clr();
    pulse_sleep();
    pin_chg = 8'h80; cyc(); pin_chg = 8'h00;
    chk("R10 bit7 inhibited", {wake, asleep}, 2'b01);
    iwake_en = 1'b0;
    pin_chg = 8'h80; cyc(); pin_chg = 8'h00;
    chk("R10 bit7 restored", {wake, asleep}, 2'b10);

    iwake_en = 1'b1; psa = 1'b0;
    pulse_clr();
    pulse_sleep();
    ticks(period(0, 0)); cyc();
    chk("R7 iwake", {wake, sys_rst, to_flag, pd_flag, asleep}, 5'b10000);

    iwake_en = 1'b0;
    pulse_clr();
    pulse_sleep();
    ticks(period(0, 0)); cyc();
    chk("R6 sleep ovf reset", {wake, sys_rst, to_flag, pd_flag}, 4'b0100);
    meas(n);
    wdt_en = 1'b0;

    ext_rst_en = 1'b0; ext_rst_n = 1'b0;
    cyc(); cyc(); cyc();
    chk("R3 pin disabled", {sys_rst, to_flag, pd_flag}, 3'b000);
    ext_rst_en = 1'b1;
    cyc(); cyc();
    ext_rst_n = 1'b1;
    chk("R3 running ext keeps flags", {sys_rst, to_flag, pd_flag}, 3'b100);
    meas(n);
    chk("R3 ext hold", n, LDLY);
    pulse_sleep();
    ext_rst_n = 1'b0; cyc(); ext_rst_n = 1'b1;
    chk("R3 sleep ext", {sys_rst, to_flag, pd_flag, asleep}, 4'b1100);
    meas(n);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule